// File: doc/BRIEF.md
# Multicycle Accumulator Processor Sequencer

A small processor that steps through fetch, decode and execute against one byte-wide memory port with a 16-bit address. Each instruction is split into a fixed series of states. Each state makes at most one bus access. A read address driven in one state returns its data in the next state, where the sequencer captures it. The architectural state is an instruction pointer, an instruction register, two 8-bit general registers (AX and BX), a 16-bit stack pointer, a 16-bit hold register and an 8-bit adder.

The instruction set has five opcodes: load an immediate byte into AX or BX, add BX into AX, push AX onto an upward-growing stack, and call an absolute 16-bit target. Any other opcode stops the processor until the next reset. A system connects a synchronous byte memory to the port, places a program at address 0, releases reset and watches the write strobe and the halt flag.

Top module: `acc_cpu_seq`

## Requirements
- R1: While reset (rst_n low) is asserted, the processor has IP = 0x0000, SP = 0x8000 and AX = BX = 0. It drives address 0x0000 with mem_we low and halted low. A push or add before any load therefore stores 0x00, and the first push goes to 0x8000.
- R2: Every instruction begins with a fetch state that drives IP on mem_addr. The next state is decode, which captures mem_rdata as the opcode and increments IP. Cycle counts from the first fetch state are: load 4, add 3, push 3, call 6. An undefined opcode takes 2 cycles before halted rises.
- R3: Opcode 0x01 (load AX) and opcode 0x02 (load BX) read the byte at the following address into the named register. They also advance IP past that byte.
- R4: Opcode 0x03 sets AX to (AX + BX) mod 256 and leaves BX unchanged.
- R5: Opcode 0x04 drives SP on mem_addr and AX on mem_wdata, with mem_we high for exactly one cycle. SP then increases by one, so consecutive pushes go to consecutive addresses.
- R6: Opcode 0x05 reads a 16-bit target from the next two bytes, low byte first, into the hold register. It then loads the target into IP, and execution continues at the target.
- R7: Any opcode other than 0x01 to 0x05 raises halted in the cycle after decode. From then until reset, halted stays high, mem_we stays low and mem_addr holds the undefined opcode's address plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory address for the current state |
| mem_rdata | input | 8 | Read data for the address driven in the previous cycle |
| mem_wdata | output | 8 | Write data (AX) |
| mem_we | output | 1 | Write strobe, one cycle per push |
| halted | output | 1 | High once an undefined opcode has been decoded |

## Verification
The bench targets the following corners, and each one shows up in an observable way:
- **Add carry out of bit 7.** The sum must wrap to 0x10. A design that kept the carry, or wrote the sum to the wrong register, pushes the wrong byte.
- **Call target above 0x00FF.** This exposes a byte swap in the hold register. A swapped design jumps into empty memory and halts at the wrong address.
- **Pushes before any load.** These check the reset values of AX, BX and SP.
- **Programs with many back-to-back pushes.** A stack pointer that is bumped early or not at all puts the pushed bytes at the wrong addresses.
- **Exact cycle count to halt, in random programs.** A missing or extra state in any instruction changes this count.
- **Halt behaviour.** After the halt, the bench watches for stray writes or a drifting address.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_DECODE,
    ST_IMM_ADR,
    ST_IMM_CAP,
    ST_ADD,
    ST_PUSH,
    ST_TGT_LO,
    ST_TGT_HI,
    ST_TGT_CAP,
    ST_JUMP,
    ST_HALT
  } seq_state_e;

  localparam logic [7:0] OPC_LDA = 8'h01;
  localparam logic [7:0] OPC_LDB = 8'h02;
  localparam logic [7:0] OPC_ADD = 8'h03;
  localparam logic [7:0] OPC_PSH = 8'h04;
  localparam logic [7:0] OPC_CAL = 8'h05;

  typedef enum logic {BUS_IP, BUS_SP} bus_src_e;

  typedef struct packed {
    logic     ir_load;
    logic     ip_inc;
    logic     ip_jump;
    logic     ax_from_bus;
    logic     bx_from_bus;
    logic     ax_from_alu;
    logic     sp_inc;
    logic     hold_lo;
    logic     hold_hi;
    logic     wr;
    bus_src_e src;
  } seq_ctl_t;

  // State that follows decode for a given opcode byte.
  function automatic seq_state_e after_decode(input logic [7:0] op);
    case (op)
      OPC_LDA, OPC_LDB: return ST_IMM_ADR;
      OPC_ADD:          return ST_ADD;
      OPC_PSH:          return ST_PUSH;
      OPC_CAL:          return ST_TGT_LO;
      default:          return ST_HALT;
    endcase
  endfunction

endpackage

// File: rtl/acc_seq_alu.sv
module acc_seq_alu #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] sum
);

  // Modular add; the carry out is discarded.
  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [DATA_W:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[DATA_W-1:0];
  endfunction

  assign sum = wrap_add(opa, opb);

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] op_byte,
  input  logic [DATA_W-1:0] ir_q,
  output seq_ctl_t          ctl,
  output logic              ev_decode,
  output logic              ev_add,
  output logic              ev_jump,
  output logic              halted
);

  seq_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_FETCH:   state_d = ST_DECODE;
      ST_DECODE:  state_d = after_decode(op_byte[7:0]);
      ST_IMM_ADR: state_d = ST_IMM_CAP;
      ST_IMM_CAP: state_d = ST_FETCH;
      ST_ADD:     state_d = ST_FETCH;
      ST_PUSH:    state_d = ST_FETCH;
      ST_TGT_LO:  state_d = ST_TGT_HI;
      ST_TGT_HI:  state_d = ST_TGT_CAP;
      ST_TGT_CAP: state_d = ST_JUMP;
      ST_JUMP:    state_d = ST_FETCH;
      ST_HALT:    state_d = ST_HALT;
      default:    state_d = ST_HALT;
    endcase
  end

  always_comb begin
    ctl     = '0;
    ctl.src = BUS_IP;
    case (state_q)
      ST_DECODE: begin
        ctl.ir_load = 1'b1;
        ctl.ip_inc  = 1'b1;
      end
      ST_IMM_ADR: ctl.ip_inc = 1'b1;
      ST_IMM_CAP: begin
        if (ir_q[7:0] == OPC_LDB) ctl.bx_from_bus = 1'b1;
        else                      ctl.ax_from_bus = 1'b1;
      end
      ST_ADD: ctl.ax_from_alu = 1'b1;
      ST_PUSH: begin
        ctl.src    = BUS_SP;
        ctl.wr     = 1'b1;
        ctl.sp_inc = 1'b1;
      end
      ST_TGT_LO: ctl.ip_inc = 1'b1;
      ST_TGT_HI: begin
        ctl.ip_inc  = 1'b1;
        ctl.hold_lo = 1'b1;
      end
      ST_TGT_CAP: ctl.hold_hi = 1'b1;
      ST_JUMP:    ctl.ip_jump = 1'b1;
      default: ;
    endcase
  end

  assign ev_decode = (state_q == ST_DECODE);
  assign ev_add    = (state_q == ST_ADD);
  assign ev_jump   = (state_q == ST_JUMP);
  assign halted    = (state_q == ST_HALT);

endmodule

// File: rtl/acc_seq_dpath.sv
module acc_seq_dpath
  import acc_seq_pkg::*;
#(
  parameter int unsigned        ADDR_W = 16,
  parameter int unsigned        DATA_W = 8,
  parameter logic [ADDR_W-1:0]  IP_RST = '0,
  parameter logic [ADDR_W-1:0]  SP_RST = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_ctl_t          ctl,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] alu_sum,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [ADDR_W-1:0] ip_q,
  output logic [ADDR_W-1:0] sp_q,
  output logic [DATA_W-1:0] ax_q,
  output logic [DATA_W-1:0] bx_q,
  output logic [ADDR_W-1:0] hold_q,
  output logic [DATA_W-1:0] ir_q
);

  localparam int unsigned HOLD_W = 2 * DATA_W;

  function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  logic [HOLD_W-1:0] hold_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip_q   <= IP_RST;
      sp_q   <= SP_RST;
      ax_q   <= '0;
      bx_q   <= '0;
      hold_r <= '0;
      ir_q   <= '0;
    end else begin
      if (ctl.ir_load) ir_q <= mem_rdata;
      if (ctl.ip_jump)     ip_q <= hold_r[ADDR_W-1:0];
      else if (ctl.ip_inc) ip_q <= step(ip_q);
      if (ctl.sp_inc) sp_q <= step(sp_q);
      if (ctl.ax_from_alu)      ax_q <= alu_sum;
      else if (ctl.ax_from_bus) ax_q <= mem_rdata;
      if (ctl.bx_from_bus) bx_q <= mem_rdata;
      if (ctl.hold_lo) hold_r[DATA_W-1:0]      <= mem_rdata;
      if (ctl.hold_hi) hold_r[HOLD_W-1:DATA_W] <= mem_rdata;
    end
  end

  assign hold_q    = hold_r[ADDR_W-1:0];
  assign mem_addr  = (ctl.src == BUS_SP) ? sp_q : ip_q;
  assign mem_wdata = ax_q;
  assign mem_we    = ctl.wr;

endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_seq_pkg::*;
#(
  parameter int unsigned       ADDR_W = 16,
  parameter int unsigned       DATA_W = 8,
  parameter logic [ADDR_W-1:0] IP_RST = 16'h0000,
  parameter logic [ADDR_W-1:0] SP_RST = 16'h8000
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted
);

  seq_ctl_t          ctl;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] ax_q;
  logic [DATA_W-1:0] bx_q;
  logic [DATA_W-1:0] alu_sum;
  logic [ADDR_W-1:0] ip_q;
  logic [ADDR_W-1:0] sp_q;
  logic [ADDR_W-1:0] hold_q;
  logic              ev_decode;
  logic              ev_add;
  logic              ev_jump;

  acc_seq_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_byte   (mem_rdata),
    .ir_q      (ir_q),
    .ctl       (ctl),
    .ev_decode (ev_decode),
    .ev_add    (ev_add),
    .ev_jump   (ev_jump),
    .halted    (halted)
  );

  acc_seq_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IP_RST (IP_RST),
    .SP_RST (SP_RST)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .alu_sum   (alu_sum),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .ip_q      (ip_q),
    .sp_q      (sp_q),
    .ax_q      (ax_q),
    .bx_q      (bx_q),
    .hold_q    (hold_q),
    .ir_q      (ir_q)
  );

  acc_seq_alu #(.DATA_W(DATA_W)) u_alu (
    .opa (ax_q),
    .opb (bx_q),
    .sum (alu_sum)
  );

endmodule

// File: rtl/acc_cpu_seq_chk.sv
module acc_cpu_seq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_we,
  input logic              halted,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] ip_q,
  input logic [ADDR_W-1:0] sp_q,
  input logic [ADDR_W-1:0] hold_q,
  input logic [DATA_W-1:0] ax_q,
  input logic [DATA_W-1:0] bx_q,
  input logic              ev_decode,
  input logic              ev_add,
  input logic              ev_jump
);

  AST_IP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_decode |=> ip_q == ADDR_W'($past(ip_q) + 1'b1)); // R2

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    ev_add |=> (ax_q == DATA_W'($past(ax_q) + $past(bx_q))) && $stable(bx_q)); // R4

  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R5

  AST_SP_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> sp_q == ADDR_W'($past(sp_q) + 1'b1)); // R5

  AST_JUMP_TGT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_jump |=> ip_q == $past(hold_q)); // R6

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(mem_addr) && !mem_we); // R7

endmodule

bind acc_cpu_seq acc_cpu_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_we    (mem_we),
  .halted    (halted),
  .mem_addr  (mem_addr),
  .ip_q      (ip_q),
  .sp_q      (sp_q),
  .hold_q    (hold_q),
  .ax_q      (ax_q),
  .bx_q      (bx_q),
  .ev_decode (ev_decode),
  .ev_add    (ev_add),
  .ev_jump   (ev_jump)
);

// File: tb/test_acc_cpu_seq.sv
module test_acc_cpu_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_rdata = 8'h00;
  logic [7:0]  mem_wdata;
  logic        mem_we;
  logic        halted;

  acc_cpu_seq i_acc_cpu_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rdata (mem_rdata),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .halted    (halted)
  );

  always #4 clk = ~clk;

  // Program memory model: 512 bytes, everything above reads 0x00.
  logic [7:0]  prog [512];
  logic [15:0] addr_s = 16'h0000;

  function automatic logic [7:0] rd_byte(input logic [15:0] a);
    return (a < 16'd512) ? prog[a[8:0]] : 8'h00;
  endfunction

  always @(negedge clk) addr_s = mem_addr;
  always @(posedge clk) mem_rdata <= rd_byte(addr_s);

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // Reference model state
  logic [15:0] m_pc, m_sp, m_halt_at;
  logic [7:0]  m_ax, m_bx;
  int          m_cyc;
  logic [15:0] exp_wa[$];
  logic [7:0]  exp_wd[$];
  string       exp_rq[$];

  function automatic logic [7:0] ref_add(input logic [7:0] a, input logic [7:0] b);
    int s;
    s = (int'(a) + int'(b)) % 256;
    return s[7:0];
  endfunction

  task automatic begin_prog();
    for (int i = 0; i < 512; i++) prog[i] = 8'h00;
    m_pc = 16'h0000; m_sp = 16'h8000; m_ax = 8'h00; m_bx = 8'h00;
    m_cyc = 0;
    exp_wa.delete(); exp_wd.delete(); exp_rq.delete();
  endtask

  task automatic emit(input logic [7:0] b);
    prog[m_pc[8:0]] = b;
    m_pc = m_pc + 16'd1;
  endtask

  task automatic t_lda(input logic [7:0] v);
    emit(8'h01); emit(v); m_ax = v; m_cyc += 4;
  endtask

  task automatic t_ldb(input logic [7:0] v);
    emit(8'h02); emit(v); m_bx = v; m_cyc += 4;
  endtask

  task automatic t_add();
    emit(8'h03); m_ax = ref_add(m_ax, m_bx); m_cyc += 3;
  endtask

  task automatic t_push(input string rq);
    emit(8'h04);
    exp_wa.push_back(m_sp); exp_wd.push_back(m_ax); exp_rq.push_back(rq);
    m_sp = m_sp + 16'd1; m_cyc += 3;
  endtask

  task automatic t_call(input logic [15:0] tgt);
    emit(8'h05); emit(tgt[7:0]); emit(tgt[15:8]);
    m_pc = tgt; m_cyc += 6;
  endtask

  task automatic t_halt(input logic [7:0] op);
    emit(op); m_halt_at = m_pc; m_cyc += 2;
  endtask

  task automatic run_prog();
    int cyc;
    int widx;
    bit seen;
    logic [15:0] a0;
    @(negedge clk) rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(mem_addr == 16'h0000, "R1", "reset address", mem_addr, 0);
    chk(!mem_we && !halted, "R1", "reset strobes", {mem_we, halted}, 0);
    rst_n = 1'b1;
    cyc = 1; widx = 0; seen = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (mem_we) begin
        if (widx < exp_wa.size()) begin
          chk(mem_addr == exp_wa[widx], exp_rq[widx], "push address", mem_addr, exp_wa[widx]);
          chk(mem_wdata == exp_wd[widx], exp_rq[widx], "push data", mem_wdata, exp_wd[widx]);
        end else begin
          chk(1'b0, "R5", "unexpected write", mem_addr, 0);
        end
        widx++;
      end
      if (halted) begin seen = 1'b1; break; end
      cyc++;
    end
    chk(seen, "R7", "halt reached", seen, 1);
    chk(cyc == m_cyc, "R2", "cycles to halt", cyc, m_cyc);
    chk(widx == exp_wa.size(), "R5", "write count", widx, exp_wa.size());
    chk(mem_addr == m_halt_at, "R7", "halt address", mem_addr, m_halt_at);
    a0 = mem_addr;
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk(halted && !mem_we && mem_addr == a0, "R7", "halt held",
          {halted, mem_we, mem_addr}, {1'b1, 1'b0, a0});
    end
  endtask

  function automatic logic [7:0] bad_op(input int r);
    int v;
    v = r % 251;
    return (v == 0) ? 8'h00 : 8'(v + 5);
  endfunction

  task automatic build_random();
    begin_prog();
    while (m_pc < 16'd400) begin
      int k;
      k = $urandom_range(0, 5);
      case (k)
        0: t_lda(8'($urandom));
        1: t_ldb(8'($urandom));
        2: t_add();
        3, 4: t_push("R5");
        default: t_call(m_pc + 16'd3 + 16'($urandom_range(0, 40)));
      endcase
    end
    t_halt(bad_op(int'($urandom_range(0, 1000))));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      nerr++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // Directed: reset values, load, add wrap, consecutive pushes, far call
    begin_prog();
    t_push("R1");
    t_add();
    t_push("R1");
    t_lda(8'h37); t_push("R3");
    t_ldb(8'h20); t_lda(8'hF0); t_add(); t_push("R4");
    t_add(); t_push("R4");
    t_call(16'h0123);
    t_lda(8'h5A); t_push("R6");
    t_halt(8'h06);
    run_prog();
    // Directed: immediate halt at address 0
    begin_prog();
    t_halt(8'hFF);
    run_prog();
    // Directed: nested calls backwards and forwards, load BX seen through add
    begin_prog();
    t_call(16'h0100);
    t_ldb(8'h11); t_call(16'h0040);
    t_add(); t_push("R6");
    t_halt(8'h00);
    run_prog();
    // Constrained random programs
    for (int p = 0; p < 30; p++) begin
      build_random();
      run_prog();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule